// File: doc/BRIEF.md
# Dual Floating-Point Context Status Tracker

This block holds the two-bit floating-point context state twice: once for the host supervisor level and once for the virtual supervisor (guest) level. Hardware uses it to decide whether an issued floating-point instruction is legal. It also marks the state dirty whenever floating-point registers are changed. Software may set either state at any time through a dedicated write port.

When virtualization is active (V=1), both copies are in force. An instruction is rejected if either copy is Off, and a state change marks both copies Dirty. When V=0, only the host copy gates instructions and only the host copy is marked. The guest copy then keeps its value unless it is written directly.

Each copy has its own summary bit. The summary bit is set when that copy's FS is Dirty or when that copy's extension-state input is Dirty. The block also presents each copy as a status-word image that uses the field positions of the virtual status register.

Top module: `fpctx_dual_tracker`

## Requirements
- R1: A synchronous active-high reset sets both FS values to Off (0). With both XS inputs below 3, both summary bits then read 0.
- R2: The FS encoding is 0 = Off, 1 = Initial, 2 = Clean, 3 = Dirty. A write strobe loads its 2-bit value into its own copy at the next clock edge and leaves the other copy unchanged.
- R3: With V=0, an issue strobe raises the illegal flag, in the same cycle, exactly when the host FS is Off. The guest FS has no effect.
- R4: With V=1, an issue strobe raises the illegal flag, in the same cycle, exactly when either FS is Off.
- R5: With V=0, a modify strobe sets the host FS to Dirty at the next edge. The guest FS is left unchanged.
- R6: With V=1, a modify strobe sets both FS values to Dirty at the next edge.
- R7: Each summary bit is 1 exactly when that copy's FS is 3 or its own XS input is 3. The host FS never affects the guest summary bit.
- R8: Each status image carries FS at bits 14:13, XS at bits 16:15 and the summary bit at the most significant bit. All other bits are 0.
- R9: When a modify strobe and a write strobe target the same copy in the same cycle, the modify strobe wins and the copy becomes Dirty.
- R10: Without an issue strobe, the illegal flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| virt_i | input | 1 | Current virtualization mode V |
| fp_issue_i | input | 1 | A floating-point instruction is issuing this cycle |
| fp_modify_i | input | 1 | Floating-point state is being changed this cycle |
| host_wr_en_i | input | 1 | Write strobe for the host FS |
| host_wr_fs_i | input | 2 | Value written into the host FS |
| guest_wr_en_i | input | 1 | Write strobe for the guest FS |
| guest_wr_fs_i | input | 2 | Value written into the guest FS |
| host_xs_i | input | 2 | Extension state summarized by the host copy |
| guest_xs_i | input | 2 | Extension state summarized by the guest copy |
| fp_illegal_o | output | 1 | The issuing floating-point instruction is illegal |
| host_fs_o | output | 2 | Host FS value |
| guest_fs_o | output | 2 | Guest FS value |
| host_sd_o | output | 1 | Host summary bit |
| guest_sd_o | output | 1 | Guest summary bit |
| host_status_o | output | HOST_W | Host status image |
| guest_status_o | output | GUEST_W | Guest status image |

## Verification
The assertions assume that reset is asserted from time zero. They also assume that the XS inputs are driven with known values once reset has been released. The stimulus meets both conditions by holding reset over the first edges, driving every input at the falling clock edge, and keeping XS at fixed values except in the directed summary-bit test.

The bench deliberately pairs a modify strobe with write strobes in the same cycle, so the R9 precedence is exercised. It never relies on a modify strobe being raised for an instruction that was flagged illegal, because upstream logic suppresses such a strobe.

// File: rtl/fpctx_pkg.sv
package fpctx_pkg;

    localparam int FS_W       = 2;
    localparam int FS_LSB     = 13;
    localparam int XS_LSB     = FS_LSB + FS_W;
    localparam int MIN_IMG_W  = XS_LSB + FS_W + 1;
    localparam int NUM_CTX    = 2;
    localparam int CTX_HOST   = 0;
    localparam int CTX_GUEST  = 1;

    typedef enum logic [FS_W-1:0] {
        FS_OFF   = 2'd0,
        FS_INIT  = 2'd1,
        FS_CLEAN = 2'd2,
        FS_DIRTY = 2'd3
    } fs_state_e;

    typedef struct packed {
        logic            wr_en;
        fs_state_e       wr_val;
        logic            mark;
        logic [FS_W-1:0] xs;
    } ctx_ctrl_t;

    function automatic logic summary_bit(fs_state_e fs, logic [FS_W-1:0] xs);
        return (fs == FS_DIRTY) || (xs == FS_W'(FS_DIRTY));
    endfunction

    function automatic logic fs_blocks(fs_state_e fs);
        return fs == FS_OFF;
    endfunction

endpackage

// File: rtl/fpctx_ctx.sv
module fpctx_ctx
    import fpctx_pkg::*;
#(
    parameter int IMG_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  ctx_ctrl_t        ctrl,
    output fs_state_e        fs_o,
    output logic             sd_o,
    output logic [IMG_W-1:0] image_o
);
    localparam int SD_POS = IMG_W - 1;

    fs_state_e fs_q;
    fs_state_e fs_d;

    always_comb begin
        fs_d = fs_q;
        if (ctrl.wr_en) fs_d = ctrl.wr_val;
        if (ctrl.mark)  fs_d = FS_DIRTY;
    end

    always_ff @(posedge clk) begin
        if (rst) fs_q <= FS_OFF;
        else     fs_q <= fs_d;
    end

    always_comb begin
        sd_o    = summary_bit(fs_q, ctrl.xs);
        image_o = '0;
        image_o[FS_LSB +: FS_W] = fs_q;
        image_o[XS_LSB +: FS_W] = ctrl.xs;
        image_o[SD_POS]         = sd_o;
    end

    assign fs_o = fs_q;

    initial begin
        if (IMG_W < MIN_IMG_W) $error("image width too small for field layout");
    end

    // R9: marking outranks a concurrent software write
    a_r9_mark_beats_write: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mark && ctrl.wr_en) |=> (fs_o == FS_DIRTY));

    // R2: an unmarked write lands as written
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (ctrl.wr_en && !ctrl.mark) |=> (fs_o == $past(ctrl.wr_val)));

    // R2: no strobe leaves the state alone
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.wr_en && !ctrl.mark) |=> $stable(fs_o));

endmodule

// File: rtl/fpctx_gate.sv
module fpctx_gate
    import fpctx_pkg::*;
(
    input  logic      virt_i,
    input  logic      issue_i,
    input  fs_state_e host_fs_i,
    input  fs_state_e guest_fs_i,
    output logic      illegal_o
);
    logic host_block;
    logic guest_block;

    always_comb begin
        host_block  = fs_blocks(host_fs_i);
        guest_block = virt_i && fs_blocks(guest_fs_i);
        illegal_o   = issue_i && (host_block || guest_block);
    end
endmodule

// File: rtl/fpctx_dual_tracker.sv
module fpctx_dual_tracker
    import fpctx_pkg::*;
#(
    parameter int HOST_W  = 64,
    parameter int GUEST_W = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               virt_i,
    input  logic               fp_issue_i,
    input  logic               fp_modify_i,
    input  logic               host_wr_en_i,
    input  logic [1:0]         host_wr_fs_i,
    input  logic               guest_wr_en_i,
    input  logic [1:0]         guest_wr_fs_i,
    input  logic [1:0]         host_xs_i,
    input  logic [1:0]         guest_xs_i,
    output logic               fp_illegal_o,
    output logic [1:0]         host_fs_o,
    output logic [1:0]         guest_fs_o,
    output logic               host_sd_o,
    output logic               guest_sd_o,
    output logic [HOST_W-1:0]  host_status_o,
    output logic [GUEST_W-1:0] guest_status_o
);
    localparam int MAX_W = (HOST_W > GUEST_W) ? HOST_W : GUEST_W;

    ctx_ctrl_t  ctrl   [NUM_CTX];
    fs_state_e  fs     [NUM_CTX];
    logic       sd     [NUM_CTX];
    logic [MAX_W-1:0] img [NUM_CTX];

    always_comb begin
        ctrl[CTX_HOST].wr_en   = host_wr_en_i;
        ctrl[CTX_HOST].wr_val  = fs_state_e'(host_wr_fs_i);
        ctrl[CTX_HOST].mark    = fp_modify_i;
        ctrl[CTX_HOST].xs      = host_xs_i;
        ctrl[CTX_GUEST].wr_en  = guest_wr_en_i;
        ctrl[CTX_GUEST].wr_val = fs_state_e'(guest_wr_fs_i);
        ctrl[CTX_GUEST].mark   = fp_modify_i && virt_i;
        ctrl[CTX_GUEST].xs     = guest_xs_i;
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        localparam int W = (c == CTX_HOST) ? HOST_W : GUEST_W;
        logic [W-1:0] img_w;
        fpctx_ctx #(.IMG_W(W)) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl[c]),
            .fs_o    (fs[c]),
            .sd_o    (sd[c]),
            .image_o (img_w)
        );
        if (W == MAX_W) begin : g_full
            assign img[c] = img_w;
        end else begin : g_pad
            assign img[c] = {{(MAX_W-W){1'b0}}, img_w};
        end
    end

    fpctx_gate u_gate (
        .virt_i     (virt_i),
        .issue_i    (fp_issue_i),
        .host_fs_i  (fs[CTX_HOST]),
        .guest_fs_i (fs[CTX_GUEST]),
        .illegal_o  (fp_illegal_o)
    );

    assign host_fs_o      = fs[CTX_HOST];
    assign guest_fs_o     = fs[CTX_GUEST];
    assign host_sd_o      = sd[CTX_HOST];
    assign guest_sd_o     = sd[CTX_GUEST];
    assign host_status_o  = img[CTX_HOST][HOST_W-1:0];
    assign guest_status_o = img[CTX_GUEST][GUEST_W-1:0];

    // R6: a modify under V=1 dirties both copies
    a_r6_both_dirty: assert property (@(posedge clk) disable iff (rst)
        (virt_i && fp_modify_i) |=> (host_fs_o == 2'd3 && guest_fs_o == 2'd3));

    // R5: a modify under V=0 dirties the host and spares the guest
    a_r5_host_only: assert property (@(posedge clk) disable iff (rst)
        (!virt_i && fp_modify_i && !guest_wr_en_i) |=> (host_fs_o == 2'd3 && $stable(guest_fs_o)));

    // R7: the guest summary does not follow the host copy
    a_r7_guest_sd_isolated: assert property (@(posedge clk) disable iff (rst)
        ($stable(guest_fs_o) && $stable(guest_xs_i)) |-> $stable(guest_sd_o));

    // R10: no issue, no illegal flag
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        !fp_issue_i |-> !fp_illegal_o);

    // R4: a dirty pair under V=1 never blocks an issue
    a_r4_dirty_pass: assert property (@(posedge clk) disable iff (rst)
        (virt_i && host_fs_o == 2'd3 && guest_fs_o == 2'd3) |-> !fp_illegal_o);

endmodule

// File: tb/sim_fpctx_dual_tracker.sv
module sim_fpctx_dual_tracker;
    localparam int HW = 64;
    localparam int GW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic virt = 0, issue = 0, modify = 0, hwe = 0, gwe = 0;
    logic [1:0] hfs = 0, gfs = 0, hxs = 0, gxs = 0;
    logic ill, hsd, gsd;
    logic [1:0] hfs_o, gfs_o;
    logic [HW-1:0] himg;
    logic [GW-1:0] gimg;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    fpctx_dual_tracker #(.HOST_W(HW), .GUEST_W(GW)) u0 (
        .clk(clk), .rst(rst), .virt_i(virt), .fp_issue_i(issue), .fp_modify_i(modify),
        .host_wr_en_i(hwe), .host_wr_fs_i(hfs), .guest_wr_en_i(gwe), .guest_wr_fs_i(gfs),
        .host_xs_i(hxs), .guest_xs_i(gxs), .fp_illegal_o(ill),
        .host_fs_o(hfs_o), .guest_fs_o(gfs_o), .host_sd_o(hsd), .guest_sd_o(gsd),
        .host_status_o(himg), .guest_status_o(gimg)
    );

    typedef struct packed {
        logic       v;
        logic       iss;
        logic       mod;
        logic       hwe;
        logic [1:0] hfs;
        logic       gwe;
        logic [1:0] gfs;
        logic       ill;
        logic [1:0] eh;
        logic [1:0] eg;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b1, 2'd0,2'd0},
        '{1'b0,1'b0,1'b0, 1'b1,2'd2, 1'b0,2'd0, 1'b0, 2'd2,2'd0},
        '{1'b0,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b0, 2'd2,2'd0},
        '{1'b1,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b1, 2'd2,2'd0},
        '{1'b1,1'b0,1'b0, 1'b0,2'd0, 1'b1,2'd1, 1'b0, 2'd2,2'd1},
        '{1'b1,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b0, 2'd2,2'd1},
        '{1'b0,1'b0,1'b1, 1'b0,2'd0, 1'b0,2'd0, 1'b0, 2'd3,2'd1},
        '{1'b0,1'b0,1'b0, 1'b1,2'd0, 1'b1,2'd2, 1'b0, 2'd0,2'd2},
        '{1'b1,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b1, 2'd0,2'd2},
        '{1'b0,1'b0,1'b0, 1'b1,2'd1, 1'b0,2'd0, 1'b0, 2'd1,2'd2},
        '{1'b1,1'b0,1'b1, 1'b0,2'd0, 1'b0,2'd0, 1'b0, 2'd3,2'd3},
        '{1'b1,1'b0,1'b1, 1'b1,2'd1, 1'b1,2'd0, 1'b0, 2'd3,2'd3},
        '{1'b0,1'b0,1'b1, 1'b0,2'd0, 1'b1,2'd0, 1'b0, 2'd3,2'd0},
        '{1'b1,1'b1,1'b0, 1'b0,2'd0, 1'b0,2'd0, 1'b1, 2'd3,2'd0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] img_of(input logic [1:0] fs, input logic [1:0] xs, input int w);
        logic [63:0] r = '0;
        r[14:13] = fs;
        r[16:15] = xs;
        r[w-1]   = (fs == 2'd3) || (xs == 2'd3);
        return r;
    endfunction

    task automatic idle_inputs();
        virt = 0; issue = 0; modify = 0; hwe = 0; gwe = 0; hfs = 0; gfs = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R1 reset state
        check("R1 host fs", 64'(hfs_o), 64'd0);
        check("R1 guest fs", 64'(gfs_o), 64'd0);
        check("R1 sd bits", 64'({hsd, gsd}), 64'd0);
        check("R10 idle illegal", 64'(ill), 64'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            virt = VEC[i].v; issue = VEC[i].iss; modify = VEC[i].mod;
            hwe = VEC[i].hwe; hfs = VEC[i].hfs; gwe = VEC[i].gwe; gfs = VEC[i].gfs;
            #2;
            // R3 R4 R10 illegal flag in the same cycle
            check(VEC[i].v ? "R4 illegal" : "R3 illegal", 64'(ill), 64'(VEC[i].ill));
            @(posedge clk);
            #2;
            // R2 R5 R6 R9 state after the edge
            check("R2/R5/R6/R9 host fs", 64'(hfs_o), 64'(VEC[i].eh));
            check("R2/R5/R6/R9 guest fs", 64'(gfs_o), 64'(VEC[i].eg));
            check("R7 host sd", 64'(hsd), 64'(VEC[i].eh == 2'd3));
            check("R7 guest sd", 64'(gsd), 64'(VEC[i].eg == 2'd3));
        end
        @(negedge clk);
        idle_inputs();

        // state now: host dirty, guest off
        #2;
        check("R7 guest sd ignores dirty host", 64'(gsd), 64'd0);
        check("R8 host image", himg, img_of(2'd3, 2'd0, HW));
        check("R8 guest image", gimg, img_of(2'd0, 2'd0, GW));

        // R7 XS drives summary on its own copy only
        gxs = 2'd3;
        #2;
        check("R7 guest sd from xs", 64'(gsd), 64'd1);
        check("R8 guest image xs", gimg, img_of(2'd0, 2'd3, GW));
        gxs = 2'd2; hxs = 2'd3;
        hwe = 1; hfs = 2'd1;
        @(posedge clk);
        #2;
        hwe = 0;
        check("R7 host sd from xs", 64'(hsd), 64'd1);
        check("R7 guest sd xs clean", 64'(gsd), 64'd0);
        check("R8 host image xs", himg, img_of(2'd1, 2'd3, HW));
        hxs = 2'd0; gxs = 2'd0;

        // R5 V=0 modify leaves a written guest value
        @(negedge clk);
        gwe = 1; gfs = 2'd2;
        @(negedge clk);
        gwe = 0; modify = 1; virt = 0;
        @(negedge clk);
        modify = 0;
        #2;
        check("R5 guest untouched", 64'(gfs_o), 64'd2);
        check("R5 host dirty", 64'(hfs_o), 64'd3);

        // R1 mid-run reset
        rst = 1;
        @(posedge clk);
        #2;
        rst = 0;
        check("R1 host after reset", 64'(hfs_o), 64'd0);
        check("R1 guest after reset", 64'(gfs_o), 64'd0);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule